// File: doc/BRIEF.md
# Variable Pulse Width Bus Receiver

This block listens to a single-wire automotive bus that encodes bits as pulse widths. It measures the time between line edges on a microsecond grid, which comes from a prescaled system clock. A start-of-frame pulse of the right width moves it into the data state. The width of that start pulse also fixes the bus speed for the whole frame: normal speed or four times faster. From then on, every timing window is scaled by that speed.

In the data state, each pulse is classed as short or long. The class, together with the level the line held during the pulse, gives one data bit. Bits are packed into bytes with the most significant bit first. Each completed byte is presented with a tag that names its role in the frame. When the line stays without an edge for the end-of-frame time, the block emits a frame-end pulse. Alongside it, a checksum strobe carries a copy of the last complete byte.

Top module: `vpw_rx`

## Requirements
- R1: In idle, an active-level pulse measured at 164 to 244 µs inclusive starts a frame at normal speed and clears `quad_speed`. A pulse of 245 µs or more, or below 164 µs, does not start a frame.
- R2: In idle, an active-level pulse of 41 to 60 µs inclusive starts a frame at quadruple speed and sets `quad_speed`, which holds until the next start of frame.
- R3: At normal speed a short pulse is 24–96 µs and a long pulse is 97–169 µs. At quadruple speed these become 6–23 µs and 24–41 µs.
- R4: A short pulse gives bit 1 at the active level and bit 0 at the passive level. A long pulse gives bit 0 at the active level and bit 1 at the passive level. Bits fill a byte MSB first, and after every 8th bit `byte_valid` is high for one cycle with the byte on `byte_data`.
- R5: `byte_tag` uses these codes: 0 = priority, 1 = destination, 2 = source, 3 = mode, 4 = parameter identifier, 5 = other data. Bytes at offsets 0 to 3 get codes 0 to 3. The byte at offset 4 gets code 4 when the mode byte was 0x01 and code 5 otherwise. All later bytes get code 5.
- R6: In the data state, an interval without an edge that reaches 240 µs (60 µs at quadruple speed) raises `frame_end` for one cycle. The block then returns to idle, and the next frame's byte offsets start again at 0.
- R7: When at least one byte completed in the frame, `csum_valid` pulses in the same cycle as `frame_end`, and `csum_data` holds the last complete byte. Otherwise `csum_valid` stays low.
- R8: In the data state, a pulse outside both windows produces no bit and leaves the bit position unchanged. In idle, any pulse that is not a valid start of frame produces no byte and no frame end.
- R9: `active_lvl` selects which line level is active: 0 means a low line is active, 1 means a high line is active.
- R10: During and right after reset, `byte_valid`, `frame_end`, `csum_valid`, `quad_speed` and `byte_data` are all 0.
- R11: The interval counter saturates at one step above the larger of the end-of-frame and start-of-frame limits, and never goes past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Bus data line, synchronized inside |
| active_lvl | input | 1 | Level treated as active (0 = low) |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte value |
| byte_tag | output | 3 | Role of the byte in the frame |
| quad_speed | output | 1 | Current frame runs at quadruple speed |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| csum_valid | output | 1 | One-cycle checksum strobe |
| csum_data | output | 8 | Last complete byte of the frame |

## Verification
The checker watches rules that hold on every cycle:
- the checksum strobe only appears together with the frame-end pulse;
- both pulses and the byte strobe last a single cycle;
- a byte never completes in the frame-end cycle;
- the tag code stays in range;
- the speed flag changes only on the step from idle to the data state;
- the interval counter never passes its cap.

Only the bench's scenarios can show the rest. That covers the decoded byte values and their MSB-first order, the tag sequence including the mode-dependent identifier, and the exact width limits at both speeds. It also covers rejection of stray pulses in idle, glitches skipped in mid-frame, and the checksum byte that a frame reports at its end.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [2:0] {
        TAG_PRIO = 3'd0,
        TAG_DEST = 3'd1,
        TAG_SRC  = 3'd2,
        TAG_MODE = 3'd3,
        TAG_PID  = 3'd4,
        TAG_DATA = 3'd5
    } vpw_tag_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } vpw_state_e;

endpackage

// File: rtl/vpw_sync_edge.sv
module vpw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_det,
    output logic pulse_lvl
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    // the level the line held during the pulse that just ended
    assign pulse_lvl = prev_q;
    assign edge_det  = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/vpw_us_timer.sv
module vpw_us_timer #(
    parameter int CLKS_PER_US = 125,
    parameter int SAT_US      = 245,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] us_cnt
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    logic [PW-1:0] pre_q, pre_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        pre_d = pre_q;
        cnt_d = cnt_q;
        if (clear) begin
            pre_d = '0;
            cnt_d = '0;
        end else if (pre_q == PW'(CLKS_PER_US - 1)) begin
            pre_d = '0;
            if (cnt_q != CW'(SAT_US))
                cnt_d = cnt_q + 1'b1;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
        end
    end

    assign us_cnt = cnt_q;
endmodule

// File: rtl/vpw_pulse_class.sv
module vpw_pulse_class #(
    parameter int CW        = 8,
    parameter int SOF_MIN   = 164,
    parameter int SOF_MAX   = 244,
    parameter int SHORT_MIN = 24,
    parameter int SHORT_MAX = 96,
    parameter int LONG_MIN  = 97,
    parameter int LONG_MAX  = 169,
    parameter int IFS_MIN   = 240
) (
    input  logic [CW-1:0] width,
    input  logic          quad,
    output logic          is_sof_norm,
    output logic          is_sof_quad,
    output logic          is_short,
    output logic          is_long,
    output logic [CW-1:0] ifs_lim
);
    // quadruple-speed limits: lower bound divided by 4, upper bound as the
    // largest value below the divided exclusive bound
    localparam logic [CW-1:0] NS_LO = CW'(SHORT_MIN);
    localparam logic [CW-1:0] NS_HI = CW'(SHORT_MAX);
    localparam logic [CW-1:0] NL_LO = CW'(LONG_MIN);
    localparam logic [CW-1:0] NL_HI = CW'(LONG_MAX);
    localparam logic [CW-1:0] QS_LO = CW'(SHORT_MIN / 4);
    localparam logic [CW-1:0] QS_HI = CW'((SHORT_MAX + 1) / 4 - 1);
    localparam logic [CW-1:0] QL_LO = CW'(LONG_MIN / 4);
    localparam logic [CW-1:0] QL_HI = CW'((LONG_MAX + 1) / 4 - 1);
    localparam logic [CW-1:0] SN_LO = CW'(SOF_MIN);
    localparam logic [CW-1:0] SN_HI = CW'(SOF_MAX);
    localparam logic [CW-1:0] SQ_LO = CW'(SOF_MIN / 4);
    localparam logic [CW-1:0] SQ_HI = CW'((SOF_MAX + 1) / 4 - 1);
    localparam logic [CW-1:0] IF_N  = CW'(IFS_MIN);
    localparam logic [CW-1:0] IF_Q  = CW'(IFS_MIN / 4);

    always_comb begin
        is_sof_norm = (width >= SN_LO) && (width <= SN_HI);
        is_sof_quad = (width >= SQ_LO) && (width <= SQ_HI);
        if (quad) begin
            is_short = (width >= QS_LO) && (width <= QS_HI);
            is_long  = (width >= QL_LO) && (width <= QL_HI);
            ifs_lim  = IF_Q;
        end else begin
            is_short = (width >= NS_LO) && (width <= NS_HI);
            is_long  = (width >= NL_LO) && (width <= NL_HI);
            ifs_lim  = IF_N;
        end
    end
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
    import vpw_pkg::*;
#(
    parameter int CLKS_PER_US  = 125,
    parameter int SYNC_STAGES  = 2,
    parameter int SOF_MIN_US   = 164,
    parameter int SOF_MAX_US   = 244,
    parameter int SHORT_MIN_US = 24,
    parameter int SHORT_MAX_US = 96,
    parameter int LONG_MIN_US  = 97,
    parameter int LONG_MAX_US  = 169,
    parameter int IFS_US       = 240
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       active_lvl,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic [2:0] byte_tag,
    output logic       quad_speed,
    output logic       frame_end,
    output logic       csum_valid,
    output logic [7:0] csum_data
);
    localparam int SAT_US = ((IFS_US > SOF_MAX_US) ? IFS_US : SOF_MAX_US) + 1;
    localparam int CW     = $clog2(SAT_US + 1);

    typedef struct packed {
        vpw_state_e st;
        logic       quad;
        logic [2:0] bit_cnt;
        logic [7:0] shreg;
        logic [2:0] off;
        logic       mode_one;
        logic       have_byte;
        logic [7:0] last_byte;
        logic       byte_valid;
        logic [7:0] byte_data;
        vpw_tag_e   byte_tag;
        logic       frame_end;
        logic       csum_valid;
        logic [7:0] csum_data;
    } rx_state_t;

    rx_state_t r_q, r_d;

    logic          edge_det, pulse_lvl;
    logic [CW-1:0] us_cnt, ifs_lim;
    logic          sof_n, sof_q, is_short, is_long;
    logic          in_frame;

    vpw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in),
        .edge_det(edge_det), .pulse_lvl(pulse_lvl)
    );

    vpw_us_timer #(.CLKS_PER_US(CLKS_PER_US), .SAT_US(SAT_US), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(edge_det), .us_cnt(us_cnt)
    );

    vpw_pulse_class #(
        .CW(CW), .SOF_MIN(SOF_MIN_US), .SOF_MAX(SOF_MAX_US),
        .SHORT_MIN(SHORT_MIN_US), .SHORT_MAX(SHORT_MAX_US),
        .LONG_MIN(LONG_MIN_US), .LONG_MAX(LONG_MAX_US), .IFS_MIN(IFS_US)
    ) u_class (
        .width(us_cnt), .quad(r_q.quad),
        .is_sof_norm(sof_n), .is_sof_quad(sof_q),
        .is_short(is_short), .is_long(is_long), .ifs_lim(ifs_lim)
    );

    always_comb begin
        logic       is_act;
        logic       bit_v;
        logic [7:0] nb;
        r_d            = r_q;
        r_d.byte_valid = 1'b0;
        r_d.frame_end  = 1'b0;
        r_d.csum_valid = 1'b0;
        is_act = (pulse_lvl == active_lvl);
        bit_v  = is_short ? is_act : !is_act;
        nb     = {r_q.shreg[6:0], bit_v};
        case (r_q.st)
            ST_IDLE: begin
                if (edge_det && is_act && (sof_n || sof_q)) begin
                    r_d.st        = ST_DATA;
                    r_d.quad      = !sof_n;
                    r_d.bit_cnt   = '0;
                    r_d.shreg     = '0;
                    r_d.off       = '0;
                    r_d.mode_one  = 1'b0;
                    r_d.have_byte = 1'b0;
                end
            end
            default: begin
                if (us_cnt >= ifs_lim) begin
                    r_d.st         = ST_IDLE;
                    r_d.frame_end  = 1'b1;
                    r_d.csum_valid = r_q.have_byte;
                    r_d.csum_data  = r_q.last_byte;
                    r_d.off        = '0;
                    r_d.have_byte  = 1'b0;
                end else if (edge_det && (is_short || is_long)) begin
                    if (r_q.bit_cnt == 3'd7) begin
                        r_d.byte_valid = 1'b1;
                        r_d.byte_data  = nb;
                        r_d.last_byte  = nb;
                        r_d.have_byte  = 1'b1;
                        r_d.shreg      = '0;
                        r_d.bit_cnt    = '0;
                        if (r_q.off < 3'd4)
                            r_d.byte_tag = vpw_tag_e'(r_q.off);
                        else if (r_q.off == 3'd4 && r_q.mode_one)
                            r_d.byte_tag = TAG_PID;
                        else
                            r_d.byte_tag = TAG_DATA;
                        if (r_q.off == 3'd3)
                            r_d.mode_one = (nb == 8'h01);
                        if (r_q.off != 3'd7)
                            r_d.off = r_q.off + 1'b1;
                    end else begin
                        r_d.shreg   = nb;
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.byte_tag <= TAG_PRIO;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_frame   = (r_q.st == ST_DATA);
    assign byte_valid = r_q.byte_valid;
    assign byte_data  = r_q.byte_data;
    assign byte_tag   = r_q.byte_tag;
    assign quad_speed = r_q.quad;
    assign frame_end  = r_q.frame_end;
    assign csum_valid = r_q.csum_valid;
    assign csum_data  = r_q.csum_data;
endmodule

// File: rtl/vpw_rx_chk.sv
module vpw_rx_chk #(
    parameter int CW     = 8,
    parameter int SAT_US = 245
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_valid,
    input logic [2:0]    byte_tag,
    input logic          frame_end,
    input logic          csum_valid,
    input logic          quad_speed,
    input logic          in_frame,
    input logic [CW-1:0] us_cnt
);
    // R7
    csum_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_valid |-> frame_end);

    // R6
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R6
    end_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !byte_valid);

    // R4
    byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R5
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (byte_tag <= 3'd5));

    // R2
    speed_at_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quad_speed) |-> (in_frame && !$past(in_frame)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        us_cnt <= CW'(SAT_US));
endmodule

bind vpw_rx vpw_rx_chk #(.CW(CW), .SAT_US(SAT_US)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_tag(byte_tag),
    .frame_end(frame_end), .csum_valid(csum_valid), .quad_speed(quad_speed),
    .in_frame(in_frame), .us_cnt(us_cnt)
);

// File: tb/vpw_rx_test.sv
module vpw_rx_test;
    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b1;
    logic       act = 1'b0;
    logic       cur = 1'b1;
    logic       byte_valid, quad_speed, frame_end, csum_valid;
    logic [7:0] byte_data, csum_data;
    logic [2:0] byte_tag;

    int checks = 0;
    int fails = 0;
    int cap_n = 0;
    int fe_n = 0;
    int cs_n = 0;
    logic [7:0] cs_d;
    logic [7:0] cap_d [0:31];
    logic [2:0] cap_t [0:31];
    logic [7:0] tx [0:7];

    always #4 clk = ~clk;

    vpw_rx #(.CLKS_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line), .active_lvl(act),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_tag(byte_tag),
        .quad_speed(quad_speed), .frame_end(frame_end),
        .csum_valid(csum_valid), .csum_data(csum_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (cap_n < 32) begin
                    cap_d[cap_n] = byte_data;
                    cap_t[cap_n] = byte_tag;
                end
                cap_n++;
            end
            if (frame_end) fe_n++;
            if (csum_valid) begin
                cs_n++;
                cs_d = csum_data;
            end
        end
    end

    task automatic chk(input string req, input int actv, input int expv);
        checks++;
        if (actv != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0;
        fe_n = 0;
        cs_n = 0;
    endtask

    task automatic drive(input logic lvl, input int us);
        line = lvl;
        repeat (us * CPU + 2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int sh, input int lg);
        int w;
        if (cur == act) w = b ? sh : lg;
        else            w = b ? lg : sh;
        drive(cur, w);
        cur = ~cur;
    endtask

    task automatic send_byte(input logic [7:0] v, input int sh, input int lg);
        for (int i = 7; i >= 0; i--) send_bit(v[i], sh, lg);
    endtask

    task automatic start_frame(input int sof_us);
        drive(act, sof_us);
        cur = ~act;
    endtask

    task automatic idle_line(input int us);
        cur = ~act;
        drive(cur, us);
    endtask

    function automatic int exp_tag(input int off);
        if (off < 4) return off;
        if (off == 4 && tx[3] == 8'h01) return 4;
        return 5;
    endfunction

    task automatic check_frame(input string req, input int n, input logic q);
        chk({req, " byte count"}, cap_n, n);
        for (int i = 0; i < n; i++) begin
            chk({req, " R4 byte value"}, cap_d[i], tx[i]);
            chk({req, " R5 tag"}, cap_t[i], exp_tag(i));
        end
        chk({req, " R6 frame end"}, fe_n, 1);
        chk({req, " R7 checksum strobe"}, cs_n, 1);
        chk({req, " R7 checksum byte"}, cs_d, tx[n-1]);
        chk({req, " R2 speed flag"}, quad_speed, q);
    endtask

    task automatic t_reset();
        // R10
        chk("R10 byte_valid", byte_valid, 0);
        chk("R10 frame_end", frame_end, 0);
        chk("R10 csum_valid", csum_valid, 0);
        chk("R10 quad_speed", quad_speed, 0);
        chk("R10 byte_data", byte_data, 0);
    endtask

    task automatic t_normal();
        // R1 R3 R4 R5 R6 R7, active-low line (R9)
        act = 1'b0;
        idle_line(300);
        clear_cap();
        tx[0] = 8'h68; tx[1] = 8'h6A; tx[2] = 8'hF1;
        tx[3] = 8'h01; tx[4] = 8'h0D; tx[5] = 8'hA5;
        start_frame(200);
        for (int i = 0; i < 6; i++) send_byte(tx[i], 64, 128);
        drive(cur, 300);
        check_frame("R1 normal", 6, 1'b0);
    endtask

    task automatic t_quad();
        // R2 R3 R9, active-high line, offset restarts (R6)
        act = 1'b1;
        idle_line(300);
        clear_cap();
        tx[0] = 8'h48; tx[1] = 8'h6B; tx[2] = 8'h10;
        tx[3] = 8'h22; tx[4] = 8'h3C; tx[5] = 8'h77;
        start_frame(60);
        for (int i = 0; i < 6; i++) send_byte(tx[i], 16, 32);
        drive(cur, 100);
        check_frame("R2 R9 quad", 6, 1'b1);
    endtask

    task automatic t_glitch();
        // R8: too-short pulses inside a frame leave the bit position alone
        act = 1'b0;
        idle_line(300);
        clear_cap();
        tx[0] = 8'hC3; tx[1] = 8'h5A;
        start_frame(200);
        send_byte(tx[0], 64, 128);
        for (int i = 7; i >= 4; i--) send_bit(tx[1][i], 64, 128);
        drive(cur, 10); cur = ~cur;
        for (int i = 3; i >= 1; i--) send_bit(tx[1][i], 64, 128);
        drive(cur, 10); cur = ~cur;
        send_bit(tx[1][0], 64, 128);
        drive(cur, 300);
        check_frame("R8 glitch", 2, 1'b0);
    endtask

    task automatic t_bounds();
        // R1 R3: window edges at normal speed
        act = 1'b0;
        idle_line(300);
        clear_cap();
        tx[0] = 8'hA5; tx[1] = 8'h3C;
        start_frame(164);
        send_byte(tx[0], 24, 169);
        send_byte(tx[1], 96, 97);
        drive(cur, 300);
        check_frame("R3 normal bounds", 2, 1'b0);
        // R1: 245 us start pulse is rejected
        clear_cap();
        start_frame(245);
        send_byte(8'hA5, 64, 128);
        drive(cur, 300);
        chk("R1 long start rejected bytes", cap_n, 0);
        chk("R1 long start rejected end", fe_n, 0);
        // R2 R3: quad speed edges
        clear_cap();
        tx[0] = 8'h96; tx[1] = 8'h0F;
        start_frame(41);
        send_byte(tx[0], 6, 41);
        send_byte(tx[1], 23, 24);
        drive(cur, 100);
        check_frame("R3 quad bounds", 2, 1'b1);
    endtask

    task automatic t_idle_junk();
        // R8: pulses in idle that are not a start of frame
        act = 1'b0;
        idle_line(300);
        clear_cap();
        drive(1'b0, 100);
        drive(1'b1, 64);
        drive(1'b0, 128);
        drive(1'b1, 64);
        drive(1'b0, 128);
        drive(1'b1, 300);
        chk("R8 idle junk bytes", cap_n, 0);
        chk("R8 idle junk end", fe_n, 0);
    endtask

    task automatic t_partial();
        // R7: a frame with no complete byte has no checksum strobe
        act = 1'b0;
        idle_line(300);
        clear_cap();
        start_frame(200);
        send_bit(1'b1, 64, 128);
        send_bit(1'b0, 64, 128);
        send_bit(1'b1, 64, 128);
        send_bit(1'b0, 64, 128);
        drive(cur, 300);
        chk("R7 partial bytes", cap_n, 0);
        chk("R6 partial end", fe_n, 1);
        chk("R7 partial checksum", cs_n, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_quad();
        t_glitch();
        t_bounds();
        t_idle_junk();
        t_partial();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule